// File: doc/BRIEF.md
# DMA Address Window Validator

This block sits on the inbound path of a PCIe host bridge and screens every DMA request before it can reach memory. A request carries a 16-bit requester number and a 64-bit DMA address. The requester number is folded into a small index that selects a programmable mapping entry, which names the request's context (PE). Each PE owns two address windows. Address bit 59 chooses between them: the translated window (entry 0) and the bypass window (entry 1). The chosen window's bounds decide the outcome. A request can pass straight through with bit 59 stripped, be flagged as needing IOMMU translation, or fail.

A failure freezes DMA for that PE and records the faulting address in the PE's state words. Every later request from a frozen PE is dropped until software clears the freeze. A global option turns bypass off, so every request is checked against entry 0. The MMIO side of the bridge is represented only by a per-PE MMIO freeze flag that software can set or clear and read back.

Software programs the mapping table, the windows, the per-PE control and the global option through a write-only port. A separate read port shows the two state words of any selected PE.

Top module: `dma_window_check`

## Requirements
- R1: After a synchronous active-low reset, no response is valid, every window entry is invalid, no PE is frozen, and both state words of every PE read as zero.
- R2: The mapping index is the XOR of the four 4-bit nibbles of the requester number. The PE is the mapping entry at that index, written with cfg_sel=0, cfg_idx=index and cfg_wdata[2:0]=PE. The response reports that PE on rsp_pe.
- R3: Window index is PE*2+s. s is request address bit 59 unless bypass is globally disabled, in which case s is 0. Windows are written with cfg_sel=1 (control: wdata[0] valid, wdata[1] bypass), cfg_sel=2 (lower bound) and cfg_sel=3 (upper bound).
- R4: A request that hits a valid translate-mode window within bounds gives status 1 (translate), with rsp_addr equal to the request address.
- R5: A request that hits a valid bypass-mode window within bounds gives status 0 (pass), with rsp_addr equal to the request address with bit 59 cleared.
- R6: The checked address is the request address, with bit 59 cleared when entry 1 is chosen. If it is below the lower bound or at or above the upper bound, the status is 2 (error) and rsp_addr is 0.
- R7: A request that selects a window whose valid bit is clear gives status 2 (error), whatever its address.
- R8: An error sets the DMA-frozen flag of its PE. The state word 1 of that PE then reads {1, request address bits 62:0}.
- R9: A request from a frozen PE gives status 3 (drop) with rsp_addr 0. It does not change that PE's recorded address. Other PEs are unaffected.
- R10: A write with cfg_sel=4, cfg_idx=PE and cfg_wdata[0]=1 clears that PE's DMA-frozen flag and keeps the recorded address. If an error on the same PE happens in the same cycle, the error wins.
- R11: A write with cfg_sel=5 sets the bypass-disable option from cfg_wdata[0]. While it is set, entry 0 is used even when bit 59 is set.
- R12: A write with cfg_sel=4 sets the PE's MMIO-frozen flag to cfg_wdata[1]. The flag reads back as bit 63 of state word 0 and has no effect on DMA checking.
- R13: A request accepted at one clock edge yields rsp_valid exactly at the next edge, and at no other time. A configuration write made in the same cycle as a request affects only later requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | DMA request present this cycle |
| req_rid | input | 16 | Requester number |
| req_addr | input | 64 | DMA address |
| rsp_valid | output | 1 | Check result valid |
| rsp_status | output | 2 | 0 pass, 1 translate, 2 error, 3 drop |
| rsp_pe | output | 3 | PE the request was mapped to |
| rsp_addr | output | 64 | Outgoing address (0 on error or drop) |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Configuration target selector |
| cfg_idx | input | 4 | Entry index for the selected target |
| cfg_wdata | input | 64 | Configuration write data |
| st_pe | input | 3 | PE whose state words are shown |
| st_word0 | output | 64 | State word 0 (bit 63 MMIO frozen) |
| st_word1 | output | 64 | State word 1 (bit 63 DMA frozen, 62:0 fault address) |

## Verification
Several kinds of address are sent. Low addresses exercise the translated window. Addresses with bit 59 set exercise the bypass window, and with bypass disabled the same addresses show the selector being overridden. Addresses exactly at the lower and upper bounds separate inclusive from exclusive comparisons. Full-width random addresses expose any truncation of the high bits. Requester numbers whose upper nibbles are non-zero show that the index fold uses all 16 bits. Repeated requests after a fault separate freezing from mere flagging. Same-cycle configuration-and-request pairs pin down which state a request sees, and which update wins.

// File: rtl/dwc_pkg.sv
// Package: shared widths, status codes, configuration selectors and window layout.
// Assumes 64-bit DMA addresses throughout.
package dwc_pkg;
    localparam int ADDR_W = 64;

    typedef enum logic [1:0] {
        ST_PASS  = 2'd0,
        ST_XLATE = 2'd1,
        ST_ERR   = 2'd2,
        ST_DROP  = 2'd3
    } rsp_status_e;

    typedef enum logic [2:0] {
        CS_MAP    = 3'd0,
        CS_WCTL   = 3'd1,
        CS_WLO    = 3'd2,
        CS_WHI    = 3'd3,
        CS_PECTL  = 3'd4,
        CS_GLOBAL = 3'd5
    } cfg_sel_e;

    typedef struct packed {
        logic              valid;
        logic              bypass;
        logic [ADDR_W-1:0] lo;
        logic [ADDR_W-1:0] hi;
    } win_t;
endpackage

// File: rtl/dwc_rid_map.sv
// Requester-to-PE mapping table.
// Folds the requester number into an index by XOR of equal slices, then
// reads the PE from a register table. Assumes RID_W is a multiple of MAP_IDX_W.
module dwc_rid_map #(
    parameter int RID_W     = 16,
    parameter int MAP_IDX_W = 4,
    parameter int PE_W      = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [MAP_IDX_W-1:0] wr_idx,
    input  logic [PE_W-1:0]      wr_pe,
    input  logic [RID_W-1:0]     rid,
    output logic [PE_W-1:0]      pe
);
    localparam int DEPTH  = 1 << MAP_IDX_W;
    localparam int CHUNKS = RID_W / MAP_IDX_W;

    logic [PE_W-1:0]      tbl [DEPTH];
    logic [MAP_IDX_W-1:0] idx;

    // Fold every slice of the requester number into the table index.
    always_comb begin
        idx = '0;
        for (int c = 0; c < CHUNKS; c++) begin
            idx = idx ^ rid[c*MAP_IDX_W +: MAP_IDX_W];
        end
    end

    // Hold mapping entries; clear on reset, update on a configuration write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                tbl[i] <= '0;
            end
        end else if (wr_en) begin
            tbl[wr_idx] <= wr_pe;
        end
    end

    assign pe = tbl[idx];
endmodule

// File: rtl/dwc_win_table.sv
// Window table: two entries per PE, each with valid, bypass mode and bounds.
// Entry index is PE*2 + select. Reads are combinational.
module dwc_win_table
    import dwc_pkg::*;
#(
    parameter int PE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ctl,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [PE_W:0]     wr_idx,
    input  logic [ADDR_W-1:0] wr_data,
    input  logic [PE_W:0]     rd_idx,
    output win_t              rd_win
);
    localparam int N_WIN = 2 << PE_W;

    win_t tbl [N_WIN];

    // Hold window entries; reset marks all invalid, writes update one field group.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N_WIN; i++) begin
                tbl[i] <= '0;
            end
        end else begin
            if (wr_ctl) begin
                tbl[wr_idx].valid  <= wr_data[0];
                tbl[wr_idx].bypass <= wr_data[1];
            end
            if (wr_lo) begin
                tbl[wr_idx].lo <= wr_data;
            end
            if (wr_hi) begin
                tbl[wr_idx].hi <= wr_data;
            end
        end
    end

    assign rd_win = tbl[rd_idx];
endmodule

// File: rtl/dwc_pe_state.sv
// Per-PE state: DMA freeze flag, MMIO freeze flag and logged fault address.
// A fault in the same cycle as a software clear leaves the PE frozen.
module dwc_pe_state
    import dwc_pkg::*;
#(
    parameter int PE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fault_set,
    input  logic [PE_W-1:0]   fault_pe,
    input  logic [ADDR_W-2:0] fault_addr,
    input  logic              ctl_wr,
    input  logic [PE_W-1:0]   ctl_pe,
    input  logic              ctl_clr_dma,
    input  logic              ctl_mmio,
    input  logic [PE_W-1:0]   rd_pe,
    output logic [ADDR_W-1:0] rd_word0,
    output logic [ADDR_W-1:0] rd_word1,
    output logic [(1<<PE_W)-1:0] dma_frz_vec
);
    localparam int NPE = 1 << PE_W;

    logic [NPE-1:0]    mmio_vec;
    logic [ADDR_W-2:0] log_arr [NPE];

    for (genvar p = 0; p < NPE; p++) begin : g_pe
        logic              frz_q;
        logic              mmio_q;
        logic [ADDR_W-2:0] log_q;
        logic              hit_ctl;
        logic              hit_fault;

        assign hit_ctl   = ctl_wr && (ctl_pe == PE_W'(p));
        assign hit_fault = fault_set && (fault_pe == PE_W'(p));

        // Freeze flags: software clear first, fault set overrides.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                frz_q  <= 1'b0;
                mmio_q <= 1'b0;
            end else begin
                if (hit_ctl) begin
                    if (ctl_clr_dma) begin
                        frz_q <= 1'b0;
                    end
                    mmio_q <= ctl_mmio;
                end
                if (hit_fault) begin
                    frz_q <= 1'b1;
                end
            end
        end

        // Capture the faulting address on an error for this PE.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                log_q <= '0;
            end else if (hit_fault) begin
                log_q <= fault_addr;
            end
        end

        assign dma_frz_vec[p] = frz_q;
        assign mmio_vec[p]    = mmio_q;
        assign log_arr[p]     = log_q;
    end

    assign rd_word0 = {mmio_vec[rd_pe], {(ADDR_W-1){1'b0}}};
    assign rd_word1 = {dma_frz_vec[rd_pe], log_arr[rd_pe]};
endmodule

// File: rtl/dma_window_check.sv
// DMA address window validator top.
// Maps requester to PE, selects a window by the select bit, checks bounds,
// registers the verdict one cycle after the request and freezes the PE on error.
// Assumes every request is accepted (no back-pressure).
module dma_window_check
    import dwc_pkg::*;
#(
    parameter int RID_W     = 16,
    parameter int MAP_IDX_W = 4,
    parameter int PE_W      = 3,
    parameter int SEL_BIT   = 59,
    localparam int IDX_W    = (MAP_IDX_W > PE_W + 1) ? MAP_IDX_W : PE_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [RID_W-1:0]  req_rid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              rsp_valid,
    output logic [1:0]        rsp_status,
    output logic [PE_W-1:0]   rsp_pe,
    output logic [ADDR_W-1:0] rsp_addr,
    input  logic              cfg_we,
    input  logic [2:0]        cfg_sel,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [ADDR_W-1:0] cfg_wdata,
    input  logic [PE_W-1:0]   st_pe,
    output logic [ADDR_W-1:0] st_word0,
    output logic [ADDR_W-1:0] st_word1
);
    localparam int NPE = 1 << PE_W;
    localparam logic [ADDR_W-1:0] SEL_MASK = ADDR_W'(1) << SEL_BIT;

    logic [PE_W-1:0]   req_pe;
    logic [NPE-1:0]    dma_frz_vec;
    logic              no_bypass;
    logic              sel;
    win_t              win;
    logic [ADDR_W-1:0] stripped;
    logic [ADDR_W-1:0] chk_addr;
    logic              in_range;
    rsp_status_e       verdict;
    logic [ADDR_W-1:0] out_addr;
    logic              fault_set;

    rsp_status_e       status_q;
    logic              valid_q;
    logic [PE_W-1:0]   pe_q;
    logic [ADDR_W-1:0] addr_q;

    dwc_rid_map #(
        .RID_W     (RID_W),
        .MAP_IDX_W (MAP_IDX_W),
        .PE_W      (PE_W)
    ) u_map (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (cfg_we && (cfg_sel == CS_MAP)),
        .wr_idx (cfg_idx[MAP_IDX_W-1:0]),
        .wr_pe  (cfg_wdata[PE_W-1:0]),
        .rid    (req_rid),
        .pe     (req_pe)
    );

    dwc_win_table #(
        .PE_W (PE_W)
    ) u_win (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_ctl  (cfg_we && (cfg_sel == CS_WCTL)),
        .wr_lo   (cfg_we && (cfg_sel == CS_WLO)),
        .wr_hi   (cfg_we && (cfg_sel == CS_WHI)),
        .wr_idx  (cfg_idx[PE_W:0]),
        .wr_data (cfg_wdata),
        .rd_idx  ({req_pe, sel}),
        .rd_win  (win)
    );

    dwc_pe_state #(
        .PE_W (PE_W)
    ) u_state (
        .clk         (clk),
        .rst_n       (rst_n),
        .fault_set   (fault_set),
        .fault_pe    (req_pe),
        .fault_addr  (req_addr[ADDR_W-2:0]),
        .ctl_wr      (cfg_we && (cfg_sel == CS_PECTL)),
        .ctl_pe      (cfg_idx[PE_W-1:0]),
        .ctl_clr_dma (cfg_wdata[0]),
        .ctl_mmio    (cfg_wdata[1]),
        .rd_pe       (st_pe),
        .rd_word0    (st_word0),
        .rd_word1    (st_word1),
        .dma_frz_vec (dma_frz_vec)
    );

    // Global bypass-disable option, set by software.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            no_bypass <= 1'b0;
        end else if (cfg_we && (cfg_sel == CS_GLOBAL)) begin
            no_bypass <= cfg_wdata[0];
        end
    end

    // Window select: address select bit unless bypass is disabled.
    always_comb begin
        sel      = req_addr[SEL_BIT] && !no_bypass;
        stripped = req_addr & ~SEL_MASK;
        chk_addr = sel ? stripped : req_addr;
        in_range = (chk_addr >= win.lo) && (chk_addr < win.hi);
    end

    // Verdict: frozen PE drops, invalid or out-of-bounds errors, else mode decides.
    always_comb begin
        out_addr = '0;
        if (dma_frz_vec[req_pe]) begin
            verdict = ST_DROP;
        end else if (!win.valid || !in_range) begin
            verdict = ST_ERR;
        end else if (win.bypass) begin
            verdict  = ST_PASS;
            out_addr = stripped;
        end else begin
            verdict  = ST_XLATE;
            out_addr = req_addr;
        end
    end

    assign fault_set = req_valid && (verdict == ST_ERR);

    // Response register: verdict appears one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q  <= 1'b0;
            status_q <= ST_PASS;
            pe_q     <= '0;
            addr_q   <= '0;
        end else begin
            valid_q <= req_valid;
            if (req_valid) begin
                status_q <= verdict;
                pe_q     <= req_pe;
                addr_q   <= out_addr;
            end
        end
    end

    assign rsp_valid  = valid_q;
    assign rsp_status = status_q;
    assign rsp_pe     = pe_q;
    assign rsp_addr   = addr_q;
endmodule

// File: rtl/dwc_checker.sv
// Checker for dma_window_check: response timing, freeze behaviour, bypass
// address form. Attached by bind below; observes ports and the freeze vector.
module dwc_checker #(
    parameter int PE_W    = 3,
    parameter int SEL_BIT = 59
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 req_valid,
    input logic                 rsp_valid,
    input logic [1:0]           rsp_status,
    input logic [PE_W-1:0]      rsp_pe,
    input logic [63:0]          rsp_addr,
    input logic                 cfg_we,
    input logic [2:0]           cfg_sel,
    input logic [(1<<PE_W)-1:0] frz_vec
);
    logic [(1<<PE_W)-1:0] frz_prev;

    // Freeze vector one cycle back, for drop and clear checks.
    always_ff @(posedge clk) begin
        if (!rst_n) frz_prev <= '0;
        else        frz_prev <= frz_vec;
    end

    a_r13_rsp_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    a_r13_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    a_r8_error_freezes: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_status == 2'd2) |-> frz_vec[rsp_pe]);

    a_r9_drop_only_when_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_status == 2'd3) |-> frz_prev[rsp_pe]);

    a_r5_pass_strips_select: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_status == 2'd0) |-> !rsp_addr[SEL_BIT]);

    a_r10_unfreeze_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
        ((frz_prev & ~frz_vec) != '0) |-> $past(cfg_we && cfg_sel == 3'd4));
endmodule

bind dma_window_check dwc_checker #(
    .PE_W    (PE_W),
    .SEL_BIT (SEL_BIT)
) u_dwc_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .rsp_valid  (rsp_valid),
    .rsp_status (rsp_status),
    .rsp_pe     (rsp_pe),
    .rsp_addr   (rsp_addr),
    .cfg_we     (cfg_we),
    .cfg_sel    (cfg_sel),
    .frz_vec    (dma_frz_vec)
);

// File: tb/dma_window_check_bench.sv
// Bench: behavioural reference model, compared with the design every clock.
module dma_window_check_bench;
    localparam int CLK_PERIOD = 10;
    localparam logic [63:0] B59 = 64'h0800_0000_0000_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [15:0] req_rid = '0;
    logic [63:0] req_addr = '0;
    logic        rsp_valid;
    logic [1:0]  rsp_status;
    logic [2:0]  rsp_pe;
    logic [63:0] rsp_addr;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_sel = '0;
    logic [3:0]  cfg_idx = '0;
    logic [63:0] cfg_wdata = '0;
    logic [2:0]  st_pe = '0;
    logic [63:0] st_word0;
    logic [63:0] st_word1;

    int checks = 0;
    int errors = 0;

    // reference model state
    logic [2:0]  m_map   [16];
    logic        m_valid [16];
    logic        m_byp   [16];
    logic [63:0] m_lo    [16];
    logic [63:0] m_hi    [16];
    logic        m_frz   [8];
    logic        m_mmio  [8];
    logic [62:0] m_log   [8];
    logic        m_nobyp;

    // stimulus for the next step
    logic        d_req = 1'b0;
    logic [15:0] d_rid = '0;
    logic [63:0] d_addr = '0;
    logic        d_we = 1'b0;
    logic [2:0]  d_sel = '0;
    logic [3:0]  d_idx = '0;
    logic [63:0] d_wdata = '0;
    logic [2:0]  d_st = '0;

    dma_window_check u_dma_window_check (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_rid(req_rid),
        .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_status(rsp_status),
        .rsp_pe(rsp_pe), .rsp_addr(rsp_addr), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata), .st_pe(st_pe),
        .st_word0(st_word0), .st_word1(st_word1)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [2:0] pe_of(input logic [15:0] rid);
        return m_map[rid[3:0] ^ rid[7:4] ^ rid[11:8] ^ rid[15:12]];
    endfunction

    task automatic chk(input logic ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    // One clock: drive inputs, predict, update model, compare after the edge.
    task automatic step(input string tag);
        logic        e_valid;
        logic [1:0]  e_status;
        logic [2:0]  e_pe;
        logic [63:0] e_addr;
        logic        fault;
        logic [2:0]  pe;
        logic        sel;
        int          w;
        logic [63:0] strip;
        logic [63:0] ea;
        @(negedge clk);
        req_valid = d_req; req_rid = d_rid; req_addr = d_addr;
        cfg_we = d_we; cfg_sel = d_sel; cfg_idx = d_idx; cfg_wdata = d_wdata;
        st_pe = d_st;
        e_valid = d_req; e_status = 2'd0; e_pe = '0; e_addr = '0; fault = 1'b0; pe = '0;
        if (d_req) begin
            pe = pe_of(d_rid);
            e_pe = pe;
            strip = d_addr & ~B59;
            if (m_frz[pe]) begin
                e_status = 2'd3;
            end else begin
                sel = d_addr[59] && !m_nobyp;
                w = int'(pe) * 2 + (sel ? 1 : 0);
                ea = sel ? strip : d_addr;
                if (!m_valid[w] || ea < m_lo[w] || ea >= m_hi[w]) begin
                    e_status = 2'd2;
                    fault = 1'b1;
                end else if (m_byp[w]) begin
                    e_status = 2'd0;
                    e_addr = strip;
                end else begin
                    e_status = 2'd1;
                    e_addr = d_addr;
                end
            end
        end
        if (d_we) begin
            case (d_sel)
                3'd0: m_map[d_idx] = d_wdata[2:0];
                3'd1: begin m_valid[d_idx] = d_wdata[0]; m_byp[d_idx] = d_wdata[1]; end
                3'd2: m_lo[d_idx] = d_wdata;
                3'd3: m_hi[d_idx] = d_wdata;
                3'd4: begin
                    if (d_wdata[0]) m_frz[d_idx[2:0]] = 1'b0;
                    m_mmio[d_idx[2:0]] = d_wdata[1];
                end
                3'd5: m_nobyp = d_wdata[0];
                default: ;
            endcase
        end
        if (fault) begin
            m_frz[pe] = 1'b1;
            m_log[pe] = d_addr[62:0];
        end
        @(posedge clk);
        #1;
        chk(rsp_valid === e_valid, tag, "rsp_valid", 64'(rsp_valid), 64'(e_valid));
        if (e_valid) begin
            chk(rsp_status === e_status, tag, "rsp_status", 64'(rsp_status), 64'(e_status));
            chk(rsp_pe === e_pe, tag, "rsp_pe", 64'(rsp_pe), 64'(e_pe));
            chk(rsp_addr === e_addr, tag, "rsp_addr", rsp_addr, e_addr);
        end
        chk(st_word0 === {m_mmio[d_st], 63'd0}, tag, "st_word0", st_word0, {m_mmio[d_st], 63'd0});
        chk(st_word1 === {m_frz[d_st], m_log[d_st]}, tag, "st_word1", st_word1, {m_frz[d_st], m_log[d_st]});
        d_req = 1'b0; d_we = 1'b0;
    endtask

    task automatic req(input logic [15:0] rid, input logic [63:0] addr, input string tag);
        d_req = 1'b1; d_rid = rid; d_addr = addr; d_st = pe_of(rid);
        step(tag);
    endtask

    task automatic cfg(input logic [2:0] sel, input logic [3:0] idx,
                       input logic [63:0] data, input string tag);
        d_we = 1'b1; d_sel = sel; d_idx = idx; d_wdata = data;
        step(tag);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++; checks++;
        $display("FAIL R13 watchdog actual=hung expected=finished");
        summary();
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) begin
            m_map[i] = '0; m_valid[i] = 1'b0; m_byp[i] = 1'b0; m_lo[i] = '0; m_hi[i] = '0;
        end
        for (int i = 0; i < 8; i++) begin
            m_frz[i] = 1'b0; m_mmio[i] = 1'b0; m_log[i] = '0;
        end
        m_nobyp = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: idle after reset, all state clear, windows invalid
        d_st = 3'd0; step("R1");
        d_st = 3'd5; step("R1");
        req(16'h0000, 64'h10, "R1");        // no valid window: error
        cfg(3'd4, 4'd0, 64'h1, "R1");        // clear that freeze again

        // program mapping and windows
        for (int i = 0; i < 16; i++) cfg(3'd0, 4'(i), 64'((i * 5 + 1) & 7), "R2");
        for (int p = 0; p < 8; p++) begin
            cfg(3'd1, 4'(p*2), 64'h1, "R3");
            cfg(3'd2, 4'(p*2), 64'h0, "R3");
            cfg(3'd3, 4'(p*2), 64'h8000_0000, "R3");
            cfg(3'd1, 4'(p*2+1), 64'h3, "R3");
            cfg(3'd2, 4'(p*2+1), 64'h0, "R3");
            cfg(3'd3, 4'(p*2+1), 64'h0001_0000_0000_0000, "R3");
        end

        req(16'h0000, 64'h1000, "R4");
        req(16'hAB05, 64'h4000, "R2");
        req(16'h5A30, 64'h4000, "R2");
        req(16'h0001, B59 | 64'h2_0000_0000, "R5");
        req(16'h0001, 64'h7FFF_FFFF, "R6");
        req(16'h0002, 64'h8000_0000, "R6");
        req(16'h0002, 64'h10, "R9");
        req(16'h0003, 64'h10, "R9");
        req(16'h0003, B59 | 64'h0001_0000_0000_0000, "R6");
        cfg(3'd2, 4'(int'(pe_of(16'h0004)) * 2), 64'h1000, "R6");
        req(16'h0004, 64'h1000, "R6");
        req(16'h0004, 64'hFFF, "R6");
        req(16'h0004, 64'h20, "R9");
        d_st = pe_of(16'h0002);
        cfg(3'd4, 4'(pe_of(16'h0002)), 64'h1, "R10");
        req(16'h0002, 64'h20, "R10");
        cfg(3'd1, 4'(int'(pe_of(16'h0005)) * 2 + 1), 64'h2, "R7");
        req(16'h0005, B59 | 64'h100, "R7");
        cfg(3'd5, 4'd0, 64'h1, "R11");
        req(16'h0006, B59 | 64'h100, "R11");
        req(16'h0007, 64'h100, "R11");
        cfg(3'd5, 4'd0, 64'h0, "R11");
        d_st = pe_of(16'h0007);
        cfg(3'd4, 4'(pe_of(16'h0007)), 64'h2, "R12");
        req(16'h0007, 64'h200, "R12");
        req(16'h0007, B59 | 64'h300, "R12");
        // R13: a window write in the request cycle affects only later requests
        d_req = 1'b1; d_rid = 16'h0000; d_addr = 64'h100; d_st = pe_of(16'h0000);
        d_we = 1'b1; d_sel = 3'd3; d_idx = 4'(int'(pe_of(16'h0000)) * 2); d_wdata = 64'h100;
        step("R13");
        req(16'h0000, 64'h100, "R13");
        // R10: error and clear on the same PE in one cycle, error wins
        d_req = 1'b1; d_rid = 16'h0001; d_addr = 64'h9000_0000; d_st = pe_of(16'h0001);
        d_we = 1'b1; d_sel = 3'd4; d_idx = 4'(pe_of(16'h0001)); d_wdata = 64'h1;
        step("R10");
        req(16'h0001, 64'h10, "R10");
        step("R13");

        // random traffic, compared each cycle
        for (int n = 0; n < 600; n++) begin
            d_req = ($urandom % 4) != 0;
            d_rid = 16'($urandom);
            case ($urandom % 5)
                0: d_addr = 64'($urandom & 32'h7FFF_FFFF);
                1: d_addr = 64'h8000_0000 + 64'($urandom % 16);
                2: d_addr = B59 | 64'($urandom);
                3: d_addr = B59 | 64'h0001_0000_0000_0000 | 64'($urandom % 4);
                default: d_addr = {$urandom, $urandom};
            endcase
            d_st = 3'($urandom);
            d_we = ($urandom % 3) == 0;
            d_sel = (($urandom % 8) == 0) ? 3'd5 : 3'd4;
            d_idx = 4'($urandom);
            d_wdata = 64'($urandom % 4);
            step("R9");
        end

        summary();
        $finish;
    end
endmodule